// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Port

This block connects a simple processor register bus to one asynchronous serial line in each direction. The processor sees two addresses, chosen by a single select line. At each address a write and a read reach different registers. A write at address 0 loads the transmit holding register, and a write at address 1 loads the configuration byte. A read at address 0 returns the received character, and a read at address 1 returns the status byte. While the chip select is inactive, the port ignores the strobes and does not drive the read bus.

The transmitter has two stages, so the processor can load the next character while the current one is still being shifted out. The receiver waits for the idle-high line to fall. It confirms the start bit at mid-bit with a 16x sample clock, samples each further bit at its centre, and then checks the parity bit and the first stop bit. Parity, framing and overrun errors are each reported in their own status bit. Each error flag stays set until the status register is read.

Top module: `async_serial_port`

## Requirements
- R1: While `cs` is 0, no register changes on `wr`, and `bus_oe` stays 0 with `rdata` at 0 even if `rd` is 1. While `cs` and `rd` are both 1, `bus_oe` is 1.
- R2: With `cs` at 1, `rsel`=0 selects the transmit holding register on a write and the received character on a read. `rsel`=1 selects the configuration byte on a write and the status byte on a read.
- R3: Configuration byte: bits [1:0] give the character length, 5 plus the field value. Bit 2 selects two stop bits when it is 1 and one stop bit when it is 0. Bit 3 enables parity. Bit 4 selects odd parity when it is 1 and even parity when it is 0. Bits [7:5] hold a value v that sets one bit time to 16*(v+1) clock cycles. The reset value is 0x03.
- R4: Status byte: bit0 is set when the transmit holding register is empty. Bit1 is set when a received character is waiting. Bit2 is the parity error flag, bit3 the framing error flag and bit4 the overrun error flag. Bit5 is set when the transmitter has no work. Bits [7:6] read 0. The status byte reads 0x21 after reset.
- R5: `txd` rests at 1. A transmitted frame is one 0 start bit, then the data bits with the least significant bit first, then, when enabled, a parity bit that makes the count of ones even (or odd), then one or two stop bits at 1.
- R6: The empty flag (status bit0) sets as soon as a character moves into the shift register, while bit5 stays 0. A character written during that frame starts at the tick on which the previous stop bits end, with no idle gap.
- R7: The receiver starts a frame on a 1-to-0 change of `rxd`. A low pulse that has ended by the middle of the start bit is discarded and leaves the status byte unchanged.
- R8: Only the data bits go to the received-character register, right-aligned with the unused upper bits at 0. Status bit1 then sets, and a read of the received character clears it.
- R9: When parity is enabled and the received parity bit does not match the configured sense, status bit2 sets. A matching parity bit leaves bit2 clear.
- R10: A 0 sampled in the first stop bit position sets status bit3.
- R11: A character that completes while status bit1 is still set raises status bit4 and replaces the stored character.
- R12: The error flags stay set until the status byte is read, and that read clears them. An error that arises in the same cycle as a status read stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rsel | input | 1 | Register select |
| rd | input | 1 | Read strobe, one access per cycle |
| wr | input | 1 | Write strobe, one access per cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not driven |
| bus_oe | output | 1 | Read bus drive enable |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
A status read clears the error flags, and a completing character can set one of those flags in the same cycle. The bench provokes this by holding the status address under a continuous read for the whole of a frame whose stop bit is 0. The framing flag is therefore set in a cycle that is also clearing it. The flag passes only if a read in some later cycle returns bit3 as 1. If the clear took priority, no read would ever show the flag. The transmit side has a similar collision: the loading of the holding register and its transfer into the shifter. It is judged by the exact 160-cycle spacing of two back-to-back start bits.

// File: rtl/async_serial_port.sv
module async_serial_port #(
  parameter logic [7:0] CTRL_RESET = 8'h03
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       rsel,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       bus_oe,
  output logic       txd,
  input  logic       rxd
);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;

  logic [7:0]  ctrl;
  logic [2:0]  tdiv;
  logic        tick;
  logic [3:0]  clen;
  logic        pe, podd, two;

  logic [7:0]  thr;
  logic        thr_full;
  logic [11:0] tsr, tframe;
  logic [3:0]  trem, tcnt, tbits;
  logic        tbusy, tpar, tload;

  logic [2:0]  rsync;
  logic        rline, rfall;
  rx_state_t   rstate;
  logic [3:0]  rcnt, ridx;
  logic [7:0]  rsr, rbr, rx_data;
  logic        rpar, rx_full, rx_done;
  logic        perr, ferr, oerr;

  wire wr_thr = cs & wr & ~rsel;
  wire wr_ctl = cs & wr & rsel;
  wire rd_rbr = cs & rd & ~rsel;
  wire rd_st  = cs & rd & rsel;

  assign clen = 4'd5 + {2'b00, ctrl[1:0]};
  assign two  = ctrl[2];
  assign pe   = ctrl[3];
  assign podd = ctrl[4];
  assign tick = (tdiv == ctrl[7:5]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= CTRL_RESET;
      tdiv <= '0;
    end else begin
      if (wr_ctl) ctrl <= wdata;
      tdiv <= tick ? 3'd0 : tdiv + 3'd1;
    end
  end

  always_comb begin
    tframe = '1;
    tframe[0] = 1'b0;
    tpar = podd;
    for (int i = 0; i < 8; i++) begin
      if (4'(i) < clen) begin
        tframe[i+1] = thr[i];
        tpar = tpar ^ thr[i];
      end
    end
    if (pe) tframe[clen + 4'd1] = tpar;
  end

  assign tbits = 4'd2 + clen + {3'b000, pe} + {3'b000, two};
  assign tload = tick & thr_full & (~tbusy | (tcnt == 4'd15 && trem == 4'd1));
  assign txd   = tbusy ? tsr[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr      <= '0;
      thr_full <= 1'b0;
      tsr      <= '1;
      trem     <= '0;
      tcnt     <= '0;
      tbusy    <= 1'b0;
    end else begin
      if (wr_thr) thr <= wdata;
      if (wr_thr) thr_full <= 1'b1;
      else if (tload) thr_full <= 1'b0;
      if (tbusy && tick) begin
        tcnt <= tcnt + 4'd1;
        if (tcnt == 4'd15) begin
          tsr  <= {1'b1, tsr[11:1]};
          trem <= trem - 4'd1;
          if (trem == 4'd1) tbusy <= 1'b0;
        end
      end
      if (tload) begin
        tsr   <= tframe;
        trem  <= tbits;
        tcnt  <= '0;
        tbusy <= 1'b1;
      end
    end
  end

  assign rline   = rsync[1];
  assign rfall   = rsync[2] & ~rsync[1];
  assign rx_done = (rstate == RX_BITS) && tick && rcnt == 4'd15 && ridx == clen + {3'b000, pe};
  assign rx_data = rsr >> (4'd8 - clen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsync   <= '1;
      rstate  <= RX_IDLE;
      rcnt    <= '0;
      ridx    <= '0;
      rsr     <= '0;
      rpar    <= 1'b0;
      rbr     <= '0;
      rx_full <= 1'b0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
      oerr    <= 1'b0;
    end else begin
      rsync <= {rsync[1:0], rxd};
      case (rstate)
        RX_IDLE: if (rfall) begin
          rstate <= RX_START;
          rcnt   <= '0;
        end
        RX_START: if (tick) begin
          rcnt <= rcnt + 4'd1;
          if (rcnt == 4'd7) begin
            rcnt   <= '0;
            ridx   <= '0;
            rstate <= rline ? RX_IDLE : RX_BITS;
          end
        end
        default: if (tick) begin
          rcnt <= rcnt + 4'd1;
          if (rcnt == 4'd15) begin
            ridx <= ridx + 4'd1;
            if (ridx < clen) rsr <= {rline, rsr[7:1]};
            else if (pe && ridx == clen) rpar <= rline;
            if (rx_done) rstate <= RX_IDLE;
          end
        end
      endcase

      if (rx_done) rbr <= rx_data;
      if (rx_done) rx_full <= 1'b1;
      else if (rd_rbr) rx_full <= 1'b0;

      if (rx_done && pe && (rpar != (^rx_data ^ podd))) perr <= 1'b1;
      else if (rd_st) perr <= 1'b0;
      if (rx_done && !rline) ferr <= 1'b1;
      else if (rd_st) ferr <= 1'b0;
      if (rx_done && rx_full && !rd_rbr) oerr <= 1'b1;
      else if (rd_st) oerr <= 1'b0;
    end
  end

  assign bus_oe = cs & rd;
  assign rdata  = !bus_oe ? 8'h00 :
                  rsel ? {2'b00, ~tbusy & ~thr_full, oerr, ferr, perr, rx_full, ~thr_full} : rbr;

endmodule

module async_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic rsel,
  input logic rd,
  input logic wr,
  input logic txd,
  input logic thr_full,
  input logic tbusy,
  input logic rx_done,
  input logic rx_full,
  input logic rline,
  input logic perr,
  input logic ferr,
  input logic oerr
);

  // R6
  thr_write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs && wr && !rsel |=> thr_full);

  // R5
  tx_fall_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd) |-> tbusy);

  // R8
  rbr_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs && rd && !rsel && !rx_done |=> !rx_full);

  // R8
  done_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_full);

  // R10
  stop_low_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rline |=> ferr);

  // R11
  overrun_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_full && !(cs && rd && !rsel) |=> oerr);

  // R12
  status_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs && rd && rsel && !rx_done |=> !oerr && !ferr && !perr);

endmodule

bind async_serial_port async_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rsel(rsel), .rd(rd), .wr(wr), .txd(txd),
  .thr_full(thr_full), .tbusy(tbusy), .rx_done(rx_done), .rx_full(rx_full),
  .rline(rline), .perr(perr), .ferr(ferr), .oerr(oerr)
);

// File: tb/async_serial_port_bench.sv
`timescale 1ns/1ps
module async_serial_port_bench;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, rsel = 0, rd = 0, wr = 0, rxd = 1;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic bus_oe, txd;

  async_serial_port u_async_serial_port (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rsel(rsel), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .bus_oe(bus_oe), .txd(txd), .rxd(rxd)
  );

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [7:0]  data;
    logic [3:0]  len;
    logic        pe;
    logic        odd;
    logic        two;
    logic [15:0] bt;
  } tx_item_t;

  tx_item_t exp_q[$];
  int starts[$];
  int nchk = 0, nerr = 0, cyc = 0;
  logic [3:0] cur_len = 4'd8;
  logic cur_pe = 0, cur_odd = 0, cur_two = 0;
  logic [15:0] cur_bt = 16'd16;
  logic [7:0] rv;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; rsel = sel; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_read(input logic sel, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; rsel = sel;
    #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic set_ctrl(input logic [7:0] c);
    bus_write(1'b1, c);
    cur_len = 4'd5 + {2'b00, c[1:0]};
    cur_two = c[2]; cur_pe = c[3]; cur_odd = c[4];
    cur_bt  = 16'd16 * (16'(c[7:5]) + 16'd1);
  endtask

  // driver: pushes expected frame then writes the character
  task automatic send_tx(input logic [7:0] d);
    tx_item_t it;
    it.data = d; it.len = cur_len; it.pe = cur_pe; it.odd = cur_odd;
    it.two = cur_two; it.bt = cur_bt;
    exp_q.push_back(it);
    bus_write(1'b0, d);
  endtask

  task automatic wait_tx_idle();
    logic [7:0] s;
    for (int k = 0; k < 400; k++) begin
      bus_read(1'b1, s);
      if (s[5] && exp_q.size() == 0) break;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic drive_rx(input logic [7:0] d, input int len, input logic pe,
                          input logic odd, input logic flip, input logic stopv, input int bt);
    logic p;
    p = odd;
    @(negedge clk); rxd = 0; repeat (bt) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      rxd = d[i]; p = p ^ d[i]; repeat (bt) @(negedge clk);
    end
    if (pe) begin rxd = p ^ flip; repeat (bt) @(negedge clk); end
    rxd = stopv; repeat (bt) @(negedge clk);
    rxd = 1; repeat (bt) @(negedge clk);
  endtask

  // monitor: decodes txd and compares against the scoreboard queue
  task automatic decode_frame();
    tx_item_t it;
    logic [7:0] got, mask;
    logic p;
    starts.push_back(cyc);
    if (exp_q.size() == 0) begin
      nchk++; nerr++;
      $display("FAIL R5 unexpected frame actual=1 expected=0");
      return;
    end
    it = exp_q.pop_front();
    got = '0;
    mask = 8'hFF >> (4'd8 - it.len);
    repeat (it.bt / 2) @(negedge clk);
    check("R5 start bit", txd, 1'b0);
    for (int i = 0; i < 8; i++) begin
      if (4'(i) < it.len) begin
        repeat (it.bt) @(negedge clk);
        got[i] = txd;
      end
    end
    check("R5 data lsb first", got, it.data & mask);
    if (it.pe) begin
      p = it.odd ^ (^(it.data & mask));
      repeat (it.bt) @(negedge clk);
      check("R5 parity bit", txd, p);
    end
    repeat (it.bt) @(negedge clk);
    check("R5 stop bit", txd, 1'b1);
    if (it.two) begin
      repeat (it.bt) @(negedge clk);
      check("R3 second stop bit", txd, 1'b1);
    end
  endtask

  initial begin
    logic prev;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !txd) decode_frame();
      prev = txd;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic seen;
    logic done;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset bus_oe", bus_oe, 1'b0);
    check("R5 idle txd", txd, 1'b1);
    bus_read(1'b1, rv);
    check("R4 reset status", rv, 8'h21);

    // R1: strobes without chip select
    @(negedge clk); cs = 0; wr = 1; rd = 1; rsel = 0; wdata = 8'h55;
    #1 check("R1 bus_oe idle", bus_oe, 1'b0);
    check("R1 rdata idle", rdata, 8'h00);
    @(negedge clk); rsel = 1; wdata = 8'hFF;
    @(negedge clk); wr = 0; rd = 0;
    repeat (48) @(negedge clk);
    bus_read(1'b1, rv);
    check("R1 no write taken", rv, 8'h21);

    // R2 R5: 8N1, bit time 16
    send_tx(8'hA5);
    wait_tx_idle();

    // R6: double buffering
    starts.delete();
    send_tx(8'h3C);
    for (int k = 0; k < 20; k++) begin
      bus_read(1'b1, rv);
      if (rv[0]) break;
    end
    check("R6 empty while shifting", rv[5:0], 6'h01);
    send_tx(8'hC3);
    wait_tx_idle();
    check("R6 frames back to back", (starts.size() == 2) ? starts[1] - starts[0] : -1, 160);

    // R3: 7 bits, odd parity, two stops, bit time 48
    set_ctrl(8'h5E);
    send_tx(8'h55);
    send_tx(8'h2A);
    wait_tx_idle();

    // R3: 5 bits, even parity, one stop
    set_ctrl(8'h08);
    send_tx(8'h1F);
    send_tx(8'hE6);
    wait_tx_idle();
    check("R5 scoreboard drained", exp_q.size(), 0);

    // R8: plain receive
    set_ctrl(8'h03);
    drive_rx(8'h96, 8, 0, 0, 0, 1, 16);
    bus_read(1'b1, rv); check("R8 full flag", rv, 8'h23);
    bus_read(1'b0, rv); check("R2 R8 received data", rv, 8'h96);
    bus_read(1'b1, rv); check("R8 full cleared", rv, 8'h21);

    set_ctrl(8'h02);
    drive_rx(8'h5A, 7, 0, 0, 0, 1, 16);
    bus_read(1'b0, rv); check("R8 seven bit right aligned", rv, 8'h5A);

    // R9: parity
    set_ctrl(8'h1B);
    drive_rx(8'h31, 8, 1, 1, 0, 1, 16);
    bus_read(1'b1, rv); check("R9 good parity", rv, 8'h23);
    bus_read(1'b0, rv);
    drive_rx(8'h31, 8, 1, 1, 1, 1, 16);
    repeat (40) @(negedge clk);
    bus_read(1'b1, rv); check("R9 parity error held", rv, 8'h27);
    bus_read(1'b1, rv); check("R12 read clears errors", rv, 8'h23);
    bus_read(1'b0, rv); check("R9 data kept", rv, 8'h31);

    // R10: framing
    set_ctrl(8'h03);
    drive_rx(8'h7E, 8, 0, 0, 0, 0, 16);
    bus_read(1'b1, rv); check("R10 framing flag", rv, 8'h2B);
    bus_read(1'b0, rv); check("R10 data", rv, 8'h7E);
    bus_read(1'b1, rv); check("R10 cleared", rv, 8'h21);

    // R11: overrun
    drive_rx(8'h11, 8, 0, 0, 0, 1, 16);
    drive_rx(8'h22, 8, 0, 0, 0, 1, 16);
    bus_read(1'b1, rv); check("R11 overrun flag", rv, 8'h33);
    bus_read(1'b0, rv); check("R11 newest kept", rv, 8'h22);
    bus_read(1'b1, rv); check("R11 cleared", rv, 8'h21);

    // R7: glitch rejection
    @(negedge clk); rxd = 0;
    repeat (3) @(negedge clk); rxd = 1;
    repeat (64) @(negedge clk);
    bus_read(1'b1, rv); check("R7 glitch ignored", rv, 8'h21);
    drive_rx(8'h4D, 8, 0, 0, 0, 1, 16);
    bus_read(1'b0, rv); check("R7 receive after glitch", rv, 8'h4D);

    // R12: error set in a cycle that is also a status read
    seen = 0; done = 0;
    @(negedge clk); cs = 1; rd = 1; rsel = 1;
    fork
      begin drive_rx(8'h0F, 8, 0, 0, 0, 0, 16); done = 1; end
      begin
        while (!done) begin
          #1 if (rdata[3]) seen = 1;
          @(negedge clk);
        end
      end
    join
    @(negedge clk); cs = 0; rd = 0;
    check("R12 set beats clear", seen, 1'b1);
    bus_read(1'b1, rv); check("R12 cleared by reads", rv, 8'h23);
    bus_read(1'b0, rv); check("R12 data", rv, 8'h0F);

    repeat (20) @(negedge clk);
    finish_run();
  end

endmodule